// File: doc/BRIEF.md
# Configurable Line-Code Receive Decoder

This block is the digital receive path of a T1/E1 line interface. Each cycle of the recovered receive clock it takes one dual-rail symbol: a positive-pulse flag and a negative-pulse flag. It then presents data in one of four output modes, chosen by a two-bit mode field:

- Substitution removal to single-rail NRZ: the HDB3 rules apply for E1 and the B8ZS rules for T1.
- Plain AMI decoding to single-rail NRZ.
- A retimed dual-rail pass-through.
- A raw slicer pass-through with no timing stage.

A single byte-wide configuration register holds the mode and three further controls: output polarity inversion, the clock edge on which the outputs update, and power-down. A separate selector input picks the E1 or T1 substitution rules.

The decoded modes and the retimed mode all run through one fixed-length symbol window, so they share one latency. In E1 operation, a bipolar violation is a pulse with the same polarity as the pulse before it. The window clears the marks of `000V` and `B00V` when that violation arrives behind two zero symbols. In T1 operation it clears all eight marks of `000VB0VB` when the final pulse arrives.

Top module: `lc_rx_decoder`

## Requirements
- R1: After a synchronous reset the configuration register is zero. `rd_data`, `rd_pos` and `rd_neg` are all 0 until new symbols reach the end of the window.
- R2: Configuration bits 1:0 select the mode, and value 00 with `std_t1`=0 gives E1 decoding. The block removes every `000V` and `B00V` group and drives the original binary data on `rd_data`. A symbol driven in clock cycle n appears in cycle n+8.
- R3: Mode 00 with `std_t1`=1 gives T1 decoding. The block removes every `000VB0VB` group, where V has the polarity of the pulse before the group, and drives the original binary data on `rd_data` with the same 8-cycle latency.
- R4: Mode 01 drives `rd_data` high for every pulse on either rail, with no substitution removal and 8 cycles of latency.
- R5: Mode 10 drives the input rails unchanged on `rd_pos` and `rd_neg`, 8 cycles later.
- R6: Mode 11 passes `rx_pos` and `rx_neg` to `rd_pos` and `rd_neg` in the same cycle, with no register on the way. Configuration bit 2 has no effect in this mode.
- R7: When configuration bit 3 is 1, all three data outputs are inverted (active low).
- R8: When configuration bit 2 is 1 in modes 00, 01 and 10, the outputs change on the falling clock edge. The value that appears with the rising edge in the other setting is held back until the falling edge that follows it.
- R9: When configuration bit 4 is 1, all outputs sit at the inactive level, which is the value of bit 3. The symbol window and the polarity history are cleared, so a stream that starts after power-up decodes as if it followed a reset.
- R10: In modes 00 and 01, `rd_pos` and `rd_neg` sit at the inactive level. In modes 10 and 11, `rd_data` sits at the inactive level.
- R11: Configuration bits 7:5 are stored as zero, and writing ones to them does not change the decoded output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive clock |
| rst | input | 1 | Synchronous active-high reset |
| std_t1 | input | 1 | 0 selects the E1 (HDB3) rules, 1 selects the T1 (B8ZS) rules |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte: bits 1:0 mode, bit 2 falling-edge update, bit 3 invert, bit 4 power-down, bits 7:5 reserved |
| rx_pos | input | 1 | Positive pulse seen in this symbol |
| rx_neg | input | 1 | Negative pulse seen in this symbol |
| rd_data | output | 1 | Single-rail NRZ data |
| rd_pos | output | 1 | Positive rail output |
| rd_neg | output | 1 | Negative rail output |

## Verification
Substitution removal and the falling-edge update can both act on the same symbol. The bench runs T1 and E1 streams full of long zero runs, so substitutions are frequent, with falling-edge update and inversion switched on. It samples every symbol twice: once before and once after the falling edge, and judges each sample against data from a bench-side line encoder.

A power-down can also land while a substitution is half inside the window. The bench powers down during pulse traffic, checks that the outputs sit at the inactive level, and then requires a fresh stream to decode cleanly, with no kill caused by stale polarity history.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

    typedef enum logic [1:0] {
        MODE_SUBST  = 2'b00,
        MODE_AMI    = 2'b01,
        MODE_RETIME = 2'b10,
        MODE_SLICER = 2'b11
    } rx_mode_e;

    typedef struct packed {
        logic [2:0] rsvd;
        logic       pwr_down;
        logic       invert;
        logic       fall_edge;
        rx_mode_e   mode;
    } rx_cfg_t;

    // One received symbol as it travels through the window
    typedef struct packed {
        logic raw_p;
        logic raw_n;
        logic mark;      // decoded binary one, cleared by substitution removal
        logic prev_pol;  // polarity of the pulse before this one (1 = positive)
        logic prev_vld;  // a pulse preceded this symbol since clear
    } line_sym_t;

    typedef struct packed {
        logic data;
        logic pos;
        logic neg;
    } rx_out_t;

    localparam int MIN_WINDOW = 8;
    localparam logic [7:0] CFG_KEEP_MASK = 8'h1F;

    function automatic logic sym_pulse(line_sym_t s);
        return s.raw_p | s.raw_n;
    endfunction

    function automatic logic sym_viol(line_sym_t s);
        return sym_pulse(s) && s.prev_vld && (s.raw_p == s.prev_pol);
    endfunction

endpackage

// File: rtl/lcd_window.sv
module lcd_window
    import lcd_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic t1_sel,
    input  logic in_p,
    input  logic in_n,
    output logic tail_p,
    output logic tail_n,
    output logic tail_mark
);
    localparam int D = (DEPTH < MIN_WINDOW) ? MIN_WINDOW : DEPTH;

    line_sym_t win_q [D];
    line_sym_t nxt   [D];
    logic      last_pol_q;
    logic      seen_q;
    logic      hdb3_hit;
    logic      b8zs_hit;

    always_comb begin
        nxt[0] = '{raw_p: in_p, raw_n: in_n, mark: in_p | in_n,
                   prev_pol: last_pol_q, prev_vld: seen_q};
        for (int i = 1; i < D; i++) begin
            nxt[i] = win_q[i-1];
        end
        // E1: violation behind two zeros -> clear it and the slot three back
        hdb3_hit = !t1_sel && sym_viol(nxt[0])
                   && !sym_pulse(nxt[1]) && !sym_pulse(nxt[2]);
        // T1: 000VB0VB complete when the final B arrives
        b8zs_hit = t1_sel
                   && !sym_pulse(nxt[7]) && !sym_pulse(nxt[6]) && !sym_pulse(nxt[5])
                   && sym_viol(nxt[4])
                   && sym_pulse(nxt[3]) && (nxt[3].raw_p != nxt[4].raw_p)
                   && !sym_pulse(nxt[2])
                   && sym_viol(nxt[1])
                   && sym_pulse(nxt[0]) && (nxt[0].raw_p != nxt[1].raw_p);
        if (hdb3_hit) begin
            nxt[0].mark = 1'b0;
            nxt[3].mark = 1'b0;
        end
        if (b8zs_hit) begin
            nxt[0].mark = 1'b0;
            nxt[1].mark = 1'b0;
            nxt[3].mark = 1'b0;
            nxt[4].mark = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            for (int i = 0; i < D; i++) begin
                win_q[i] <= '0;
            end
            last_pol_q <= 1'b0;
            seen_q     <= 1'b0;
        end else begin
            for (int i = 0; i < D; i++) begin
                win_q[i] <= nxt[i];
            end
            if (in_p || in_n) begin
                last_pol_q <= in_p;
                seen_q     <= 1'b1;
            end
        end
    end

    assign tail_p    = win_q[D-1].raw_p;
    assign tail_n    = win_q[D-1].raw_n;
    assign tail_mark = win_q[D-1].mark;

endmodule

// File: rtl/lcd_out_stage.sv
module lcd_out_stage
    import lcd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  rx_mode_e mode,
    input  logic     invert,
    input  logic     fall_edge,
    input  logic     pwr_down,
    input  logic     tail_p,
    input  logic     tail_n,
    input  logic     tail_mark,
    input  logic     in_p,
    input  logic     in_n,
    output logic     rd_data,
    output logic     rd_pos,
    output logic     rd_neg
);
    rx_out_t live_v;
    rx_out_t fall_q;
    rx_out_t pick_v;
    rx_out_t final_v;

    always_comb begin
        unique case (mode)
            MODE_SUBST:  live_v = '{data: tail_mark,          pos: 1'b0,   neg: 1'b0};
            MODE_AMI:    live_v = '{data: tail_p | tail_n,    pos: 1'b0,   neg: 1'b0};
            MODE_RETIME: live_v = '{data: 1'b0,               pos: tail_p, neg: tail_n};
            default:     live_v = '{data: 1'b0,               pos: in_p,   neg: in_n};
        endcase
    end

    // Copy taken half a cycle later for falling-edge update
    always_ff @(negedge clk) begin
        if (rst) begin
            fall_q <= '0;
        end else begin
            fall_q <= live_v;
        end
    end

    always_comb begin
        pick_v  = (fall_edge && mode != MODE_SLICER) ? fall_q : live_v;
        final_v = pwr_down ? rx_out_t'({3{invert}}) : rx_out_t'(pick_v ^ {3{invert}});
    end

    assign rd_data = final_v.data;
    assign rd_pos  = final_v.pos;
    assign rd_neg  = final_v.neg;

endmodule

// File: rtl/lc_rx_decoder.sv
module lc_rx_decoder
    import lcd_pkg::*;
#(
    parameter int WINDOW = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       std_t1,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_wdata,
    input  logic       rx_pos,
    input  logic       rx_neg,
    output logic       rd_data,
    output logic       rd_pos,
    output logic       rd_neg
);
    rx_cfg_t cfg_q;
    logic    tail_p;
    logic    tail_n;
    logic    tail_mark;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_wr) begin
            cfg_q <= rx_cfg_t'(cfg_wdata & CFG_KEEP_MASK);
        end
    end

    lcd_window #(.DEPTH(WINDOW)) u_window (
        .clk       (clk),
        .rst       (rst),
        .clear     (cfg_q.pwr_down),
        .t1_sel    (std_t1),
        .in_p      (rx_pos),
        .in_n      (rx_neg),
        .tail_p    (tail_p),
        .tail_n    (tail_n),
        .tail_mark (tail_mark)
    );

    lcd_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .mode      (cfg_q.mode),
        .invert    (cfg_q.invert),
        .fall_edge (cfg_q.fall_edge),
        .pwr_down  (cfg_q.pwr_down),
        .tail_p    (tail_p),
        .tail_n    (tail_n),
        .tail_mark (tail_mark),
        .in_p      (rx_pos),
        .in_n      (rx_neg),
        .rd_data   (rd_data),
        .rd_pos    (rd_pos),
        .rd_neg    (rd_neg)
    );

endmodule

// File: rtl/lcd_checker.sv
module lcd_checker (
    input logic       clk,
    input logic       rst,
    input logic       cfg_wr,
    input logic [7:0] cfg_wdata,
    input logic [7:0] cfg_q,
    input logic       rx_pos,
    input logic       rx_neg,
    input logic       rd_data,
    input logic       rd_pos,
    input logic       rd_neg
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (rd_data == 1'b0 && rd_pos == 1'b0 && rd_neg == 1'b0));

    assert_slicer_pass_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_q[1:0] == 2'b11 && !cfg_q[4]) |->
            (rd_pos == (rx_pos ^ cfg_q[3]) && rd_neg == (rx_neg ^ cfg_q[3])
             && rd_data == cfg_q[3]));

    assert_pd_inactive_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_wdata[4]) |=>
            (rd_data == $past(cfg_wdata[3]) && rd_pos == $past(cfg_wdata[3])
             && rd_neg == $past(cfg_wdata[3])));

    assert_single_rail_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg_q[1] == 1'b0 && !cfg_q[4]) |-> (rd_pos == cfg_q[3] && rd_neg == cfg_q[3]));

endmodule

bind lc_rx_decoder lcd_checker u_lcd_checker (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_q     (cfg_q),
    .rx_pos    (rx_pos),
    .rx_neg    (rx_neg),
    .rd_data   (rd_data),
    .rd_pos    (rd_pos),
    .rd_neg    (rd_neg)
);

// File: tb/tb_lc_rx_decoder.sv
`timescale 1ns/100ps
module tb_lc_rx_decoder;
    localparam int NB  = 240;
    localparam int LAT = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       std_t1 = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       rx_pos = 1'b0;
    logic       rx_neg = 1'b0;
    logic       rd_data, rd_pos, rd_neg;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit bits [NB];
    bit ep   [NB];
    bit en   [NB];

    always #2.5 clk = ~clk;

    lc_rx_decoder dut (
        .clk(clk), .rst(rst), .std_t1(std_t1), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .rx_pos(rx_pos), .rx_neg(rx_neg), .rd_data(rd_data), .rd_pos(rd_pos), .rd_neg(rd_neg)
    );

    function automatic logic [2:0] expect_at(int idx, logic [1:0] mode, logic inv);
        logic [2:0] v;
        case (mode)
            2'b00:   v = {bits[idx], 2'b00};
            2'b01:   v = {ep[idx] | en[idx], 2'b00};
            2'b10:   v = {1'b0, ep[idx], en[idx]};
            default: v = 3'b000;
        endcase
        return v ^ {3{inv}};
    endfunction

    task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr_cfg(logic [7:0] v);
        @(posedge clk); #1;
        cfg_wr = 1'b1; cfg_wdata = v;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic gen_bits(int zero_pct);
        for (int i = 0; i < NB; i++) bits[i] = (($urandom % 100) >= zero_pct);
        bits[0] = 1'b1;
    endtask

    // Independent line encoder: HDB3 when t1 = 0, B8ZS when t1 = 1
    task automatic encode(bit t1);
        bit lp = 1'b0;
        int cnt = 0;
        int i = 0;
        for (int k = 0; k < NB; k++) begin ep[k] = 1'b0; en[k] = 1'b0; end
        while (i < NB) begin
            if (!t1 && i + 3 < NB && !bits[i] && !bits[i+1] && !bits[i+2] && !bits[i+3]) begin
                if (cnt % 2 == 0) begin
                    lp = !lp;
                    ep[i] = lp; en[i] = !lp;
                end
                ep[i+3] = lp; en[i+3] = !lp;
                cnt = 0;
                i += 4;
            end else if (t1 && i + 7 < NB && !bits[i] && !bits[i+1] && !bits[i+2] && !bits[i+3]
                         && !bits[i+4] && !bits[i+5] && !bits[i+6] && !bits[i+7]) begin
                ep[i+3] = lp;  en[i+3] = !lp;
                ep[i+4] = !lp; en[i+4] = lp;
                ep[i+6] = !lp; en[i+6] = lp;
                ep[i+7] = lp;  en[i+7] = !lp;
                i += 8;
            end else begin
                if (bits[i]) begin
                    lp = !lp;
                    ep[i] = lp; en[i] = !lp;
                    cnt++;
                end
                i++;
            end
        end
    endtask

    task automatic run_stream(logic [1:0] mode, bit inv, bit fall, bit t1, logic [2:0] rsvd,
                              string req);
        std_t1 = t1;
        wr_cfg(8'h10);
        wr_cfg({rsvd, 1'b0, inv, fall, mode});
        for (int n = 0; n < NB + LAT + 1; n++) begin
            @(posedge clk); #1;
            rx_pos = (n < NB) ? ep[n] : 1'b0;
            rx_neg = (n < NB) ? en[n] : 1'b0;
            #0.5;
            if (n >= LAT && n - LAT < NB) begin
                if (fall) begin
                    if (n > LAT) chk({req, " R8 before falling edge"}, {rd_data, rd_pos, rd_neg},
                                     expect_at(n - LAT - 1, mode, inv));
                end else begin
                    chk({req, " R8 rising update"}, {rd_data, rd_pos, rd_neg},
                        expect_at(n - LAT, mode, inv));
                end
            end
            #2.5;
            if (n >= LAT && n - LAT < NB)
                chk(req, {rd_data, rd_pos, rd_neg}, expect_at(n - LAT, mode, inv));
        end
    endtask

    task automatic run_slicer(bit inv, bit fall);
        wr_cfg(8'h10);
        wr_cfg({3'b000, 1'b0, inv, fall, 2'b11});
        for (int n = 0; n < 40; n++) begin
            int r;
            @(posedge clk); #1;
            r = $urandom % 3;
            rx_pos = (r == 1);
            rx_neg = (r == 2);
            #0.5;
            chk("R6 slicer early", {rd_data, rd_pos, rd_neg}, {1'b0, rx_pos, rx_neg} ^ {3{inv}});
            #2.5;
            chk("R6 slicer late", {rd_data, rd_pos, rd_neg}, {1'b0, rx_pos, rx_neg} ^ {3{inv}});
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #3 chk("R1 reset idle", {rd_data, rd_pos, rd_neg}, 3'b000);

        gen_bits(60); encode(1'b0); run_stream(2'b00, 1'b0, 1'b0, 1'b0, 3'b000, "R2 E1");
        gen_bits(75); encode(1'b1); run_stream(2'b00, 1'b0, 1'b0, 1'b1, 3'b000, "R3 T1");
        gen_bits(50); encode(1'b0); run_stream(2'b01, 1'b0, 1'b0, 1'b0, 3'b000, "R4 AMI");
        gen_bits(50); encode(1'b1); run_stream(2'b10, 1'b0, 1'b0, 1'b1, 3'b000, "R5 R10 retime");
        gen_bits(70); encode(1'b0); run_stream(2'b00, 1'b1, 1'b0, 1'b0, 3'b000, "R7 invert");
        gen_bits(70); encode(1'b1); run_stream(2'b00, 1'b1, 1'b1, 1'b1, 3'b000, "R8 R7 T1 fall");
        gen_bits(60); encode(1'b0); run_stream(2'b10, 1'b1, 1'b1, 1'b0, 3'b000, "R8 R10 retime fall");
        gen_bits(70); encode(1'b1); run_stream(2'b00, 1'b0, 1'b1, 1'b1, 3'b111, "R11 reserved");
        run_slicer(1'b0, 1'b0);
        run_slicer(1'b1, 1'b1);

        // Power-down under pulse traffic, last pulse positive
        wr_cfg(8'h18);
        for (int n = 0; n < 20; n++) begin
            @(posedge clk); #1;
            rx_pos = (n % 3 == 1) || (n == 19);
            rx_neg = (n % 3 == 2) && (n != 19);
            #3;
            chk("R9 powered down", {rd_data, rd_pos, rd_neg}, 3'b111);
        end
        gen_bits(65); encode(1'b0); run_stream(2'b00, 1'b0, 1'b0, 1'b0, 3'b000, "R9 clean restart");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired before bench completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule